// File: doc/BRIEF.md
# Tile Shape Configuration Register Unit

This unit keeps the shape state for a small bank of matrix tile registers. Software hands it a 64-byte configuration image, which arrives over a load port that is a parameterised number of bytes wide. The unit checks the image as the bytes stream in. When the last beat arrives it does one of three things: it commits the image, it enters the init state, or it rejects the image with a fault and keeps the old configuration.

For every tile the unit stores a row count and a bytes-per-row value. A read port returns the stored state in the same image layout, so a later store of the configuration can be rebuilt byte for byte. Two events return the unit to the init state: a release command, or an image whose palette byte is zero. In both cases the unit sends a one-cycle clear request to the tile data storage, and the readback then gives all zeros.

Top module: `tcfg_state_unit`

## Requirements
- R1: An image is 64 bytes sent in 64/BUS_BYTES beats, one beat per cycle with `ld_valid` high. Lane j of beat b carries image byte b*BUS_BYTES+j, and lane 0 sits in bits 7:0. The image takes effect on its final beat, and the status outputs show the result in the cycle after that edge.
- R2: Image layout. Byte 0 is the palette. The bytes-per-row value of tile t is a little-endian 16-bit field, with its low byte at 16+2t and its high byte at 17+2t. The row count of tile t is byte 48+t. Every other byte is reserved.
- R3: An image with palette 1 that passes every check sets `cfg_valid`. Its row counts and bytes-per-row values are stored and can be read back.
- R4: An image with palette 0 puts the unit in the init state, whatever its other bytes hold. `tile_clr` pulses for one cycle, `cfg_valid` clears, all stored fields become zero, and no fault is raised.
- R5: An image is rejected if any of these holds: the palette is above 1, a row count is above 16, a bytes-per-row value is above 64, or a reserved byte is nonzero. The limits 16 rows and 64 bytes are themselves accepted. A rejected image pulses `cfg_fault` for one cycle and leaves `cfg_valid` and the stored fields unchanged.
- R6: `rd_beat` selects one beat of the stored image, using the lane layout of R1. The result appears on `rd_data` combinationally. While `cfg_valid` is low, every byte reads as zero.
- R7: A `rel_req` cycle puts the unit in the init state and pulses `tile_clr`. It also abandons any partly received image, so the next load beat is byte group 0 of a new image.
- R8: If `rel_req` arrives in the same cycle as the final beat of an image, the release wins. The image is neither committed nor faulted.
- R9: After reset, `cfg_valid`, `cfg_fault` and `tile_clr` are low and the readback is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load beat present on `ld_data` |
| ld_data | input | 8*BUS_BYTES | Image bytes of the current beat |
| rel_req | input | 1 | Release command, return to init state |
| rd_beat | input | log2(64/BUS_BYTES) | Beat index for readback |
| rd_data | output | 8*BUS_BYTES | Readback bytes of the selected beat |
| cfg_valid | output | 1 | A valid nonzero-palette configuration is held |
| cfg_fault | output | 1 | One-cycle pulse: last image rejected |
| tile_clr | output | 1 | One-cycle pulse: clear tile data storage |

## Verification
The bench builds the unit with its defaults, BUS_BYTES=4 and NUM_TILES=8, so an image takes 16 beats and the field area covers bytes 16 to 31 and 48 to 55. With four-byte lanes, the low and high bytes of one bytes-per-row field land in the same beat, and the row counts of tiles 0 to 3 share a beat. This lets the bench test per-lane decoding of mixed field kinds and catch a misplaced lane. The eight tiles also reach the last field bytes (31 and 55) next to reserved bytes, where an off-by-one in the range decode would show up as a false fault or a missing one.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;

  localparam int IMG_BYTES = 64;
  localparam int PAL_BYTE  = 0;
  localparam int BPR_BASE  = 16;
  localparam int ROWS_BASE = 48;
  localparam int ROW_LIMIT = 16;
  localparam int BPR_LIMIT = 64;
  localparam int TILE_CAP  = 8;

  typedef enum logic [2:0] {
    FK_RSVD,
    FK_PAL,
    FK_BPR_LO,
    FK_BPR_HI,
    FK_ROWS
  } fkind_e;

  typedef struct packed {
    fkind_e     kind;
    logic [2:0] tile;
  } fdec_t;

  // Classify an absolute image byte offset for a bank of nt tiles.
  function automatic fdec_t decode_byte(input int a, input int nt);
    fdec_t d;
    d.kind = FK_RSVD;
    d.tile = '0;
    if (a == PAL_BYTE) begin
      d.kind = FK_PAL;
    end else if (a >= BPR_BASE && a < BPR_BASE + 2 * nt) begin
      d.kind = ((a - BPR_BASE) % 2 == 1) ? FK_BPR_HI : FK_BPR_LO;
      d.tile = 3'((a - BPR_BASE) / 2);
    end else if (a >= ROWS_BASE && a < ROWS_BASE + nt) begin
      d.kind = FK_ROWS;
      d.tile = 3'(a - ROWS_BASE);
    end
    return d;
  endfunction

  // Per-byte legality against the field it occupies.
  function automatic logic byte_bad(input fkind_e k, input logic [7:0] v);
    case (k)
      FK_PAL:    return v > 8'd1;
      FK_BPR_LO: return v > 8'(BPR_LIMIT);
      FK_ROWS:   return v > 8'(ROW_LIMIT);
      default:   return v != 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/tcfg_stage.sv
module tcfg_stage
  import tcfg_pkg::*;
#(
  parameter int NUM_TILES = 8,
  parameter int BUS_BYTES = 4,
  localparam int BEATS = IMG_BYTES / BUS_BYTES,
  localparam int BW    = $clog2(BEATS),
  localparam int LW    = 8 * BUS_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [LW-1:0] ld_data,
  input  logic          abort,
  output logic          done,
  output logic          load_err,
  output logic          pal_nz,
  output logic [6:0]    bpr_nx  [NUM_TILES],
  output logic [4:0]    rows_nx [NUM_TILES]
);

  logic [BW-1:0] beat_q, beat_d;
  logic          err_q, err_d;
  logic          pal_nz_q, pal_nz_d;
  logic [6:0]    bpr_q  [NUM_TILES];
  logic [6:0]    bpr_d  [NUM_TILES];
  logic [4:0]    rows_q [NUM_TILES];
  logic [4:0]    rows_d [NUM_TILES];
  logic          beat_err;
  logic          last_beat;

  fdec_t       lane_dec [BUS_BYTES];
  logic [7:0]  lane_val [BUS_BYTES];

  for (genvar j = 0; j < BUS_BYTES; j++) begin : g_lane
    assign lane_dec[j] = decode_byte(int'(beat_q) * BUS_BYTES + j, NUM_TILES);
    assign lane_val[j] = ld_data[8*j +: 8];
  end

  always_comb begin
    last_beat = (beat_q == BW'(BEATS - 1));
    beat_err  = 1'b0;
    pal_nz_d  = pal_nz_q;
    bpr_d     = bpr_q;
    rows_d    = rows_q;
    if (ld_valid) begin
      for (int j = 0; j < BUS_BYTES; j++) begin
        beat_err = beat_err | byte_bad(lane_dec[j].kind, lane_val[j]);
        case (lane_dec[j].kind)
          FK_PAL:    pal_nz_d = (lane_val[j] != 8'd0);
          FK_BPR_LO: bpr_d[lane_dec[j].tile] = lane_val[j][6:0];
          FK_ROWS:   rows_d[lane_dec[j].tile] = lane_val[j][4:0];
          default:   ;
        endcase
      end
    end
    load_err = ((beat_q == '0) ? 1'b0 : err_q) | beat_err;
    done     = ld_valid & ~abort & last_beat;
    if (abort) begin
      beat_d = '0;
      err_d  = 1'b0;
    end else begin
      beat_d = last_beat ? '0 : beat_q + 1'b1;
      err_d  = load_err;
    end
  end

  assign pal_nz  = pal_nz_d;
  assign bpr_nx  = bpr_d;
  assign rows_nx = rows_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q   <= '0;
      err_q    <= 1'b0;
      pal_nz_q <= 1'b0;
      for (int t = 0; t < NUM_TILES; t++) begin
        bpr_q[t]  <= '0;
        rows_q[t] <= '0;
      end
    end else begin
      if (ld_valid | abort) begin
        beat_q <= beat_d;
        err_q  <= err_d;
      end
      if (ld_valid) begin
        pal_nz_q <= pal_nz_d;
        bpr_q    <= bpr_d;
        rows_q   <= rows_d;
      end
    end
  end

endmodule

// File: rtl/tcfg_readback.sv
module tcfg_readback
  import tcfg_pkg::*;
#(
  parameter int NUM_TILES = 8,
  parameter int BUS_BYTES = 4,
  localparam int BEATS = IMG_BYTES / BUS_BYTES,
  localparam int BW    = $clog2(BEATS),
  localparam int LW    = 8 * BUS_BYTES
) (
  input  logic [BW-1:0] rd_beat,
  input  logic          cfg_valid,
  input  logic [6:0]    bpr  [NUM_TILES],
  input  logic [4:0]    rows [NUM_TILES],
  output logic [LW-1:0] rd_data
);

  for (genvar j = 0; j < BUS_BYTES; j++) begin : g_lane
    fdec_t      dec;
    logic [7:0] byte_q;
    assign dec = decode_byte(int'(rd_beat) * BUS_BYTES + j, NUM_TILES);
    always_comb begin
      case (dec.kind)
        FK_PAL:    byte_q = {7'd0, cfg_valid};
        FK_BPR_LO: byte_q = {1'b0, bpr[dec.tile]};
        FK_ROWS:   byte_q = {3'd0, rows[dec.tile]};
        default:   byte_q = 8'd0;
      endcase
    end
    assign rd_data[8*j +: 8] = byte_q;
  end

endmodule

// File: rtl/tcfg_state_unit.sv
module tcfg_state_unit
  import tcfg_pkg::*;
#(
  parameter int NUM_TILES = 8,
  parameter int BUS_BYTES = 4,
  localparam int BEATS = IMG_BYTES / BUS_BYTES,
  localparam int BW    = $clog2(BEATS),
  localparam int LW    = 8 * BUS_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [LW-1:0] ld_data,
  input  logic          rel_req,
  input  logic [BW-1:0] rd_beat,
  output logic [LW-1:0] rd_data,
  output logic          cfg_valid,
  output logic          cfg_fault,
  output logic          tile_clr
);

  logic       img_done, img_err, img_pal_nz;
  logic [6:0] bpr_nx  [NUM_TILES];
  logic [4:0] rows_nx [NUM_TILES];

  logic       valid_q, valid_d;
  logic       fault_q, fault_d;
  logic       clr_q, clr_d;
  logic       fld_en;
  logic [6:0] bpr_q  [NUM_TILES];
  logic [6:0] bpr_d  [NUM_TILES];
  logic [4:0] rows_q [NUM_TILES];
  logic [4:0] rows_d [NUM_TILES];

  tcfg_stage #(
    .NUM_TILES(NUM_TILES),
    .BUS_BYTES(BUS_BYTES)
  ) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_data  (ld_data),
    .abort    (rel_req),
    .done     (img_done),
    .load_err (img_err),
    .pal_nz   (img_pal_nz),
    .bpr_nx   (bpr_nx),
    .rows_nx  (rows_nx)
  );

  // Commit decision: release, then init image, then fault, then accept.
  always_comb begin
    valid_d = valid_q;
    fault_d = 1'b0;
    clr_d   = 1'b0;
    bpr_d   = bpr_q;
    rows_d  = rows_q;
    if (rel_req || (img_done && !img_pal_nz)) begin
      valid_d = 1'b0;
      clr_d   = 1'b1;
      for (int t = 0; t < NUM_TILES; t++) begin
        bpr_d[t]  = '0;
        rows_d[t] = '0;
      end
    end else if (img_done && img_err) begin
      fault_d = 1'b1;
    end else if (img_done) begin
      valid_d = 1'b1;
      bpr_d   = bpr_nx;
      rows_d  = rows_nx;
    end
  end

  assign fld_en = rel_req | img_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      clr_q   <= 1'b0;
      for (int t = 0; t < NUM_TILES; t++) begin
        bpr_q[t]  <= '0;
        rows_q[t] <= '0;
      end
    end else begin
      fault_q <= fault_d;
      clr_q   <= clr_d;
      if (fld_en) begin
        valid_q <= valid_d;
        bpr_q   <= bpr_d;
        rows_q  <= rows_d;
      end
    end
  end

  tcfg_readback #(
    .NUM_TILES(NUM_TILES),
    .BUS_BYTES(BUS_BYTES)
  ) u_rdbk (
    .rd_beat   (rd_beat),
    .cfg_valid (valid_q),
    .bpr       (bpr_q),
    .rows      (rows_q),
    .rd_data   (rd_data)
  );

  assign cfg_valid = valid_q;
  assign cfg_fault = fault_q;
  assign tile_clr  = clr_q;

endmodule

// File: rtl/tcfg_checker.sv
module tcfg_checker #(
  parameter int BUS_BYTES = 4,
  localparam int LW = 8 * BUS_BYTES
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_valid,
  input logic          rel_req,
  input logic [LW-1:0] rd_data,
  input logic          cfg_valid,
  input logic          cfg_fault,
  input logic          tile_clr
);

  a_r5_fault_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fault |-> $stable(cfg_valid));

  a_r5_fault_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fault |=> !cfg_fault);

  a_r4_clear_means_init: assert property (@(posedge clk) disable iff (!rst_n)
    tile_clr |-> (!cfg_valid && !cfg_fault));

  a_r7_release_inits: assert property (@(posedge clk) disable iff (!rst_n)
    rel_req |=> (tile_clr && !cfg_valid));

  a_r6_unconfigured_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> (rd_data == '0));

  a_r3_valid_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) |-> ($past(ld_valid) && !$past(rel_req)));

endmodule

bind tcfg_state_unit tcfg_checker #(
  .BUS_BYTES(BUS_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_valid  (ld_valid),
  .rel_req   (rel_req),
  .rd_data   (rd_data),
  .cfg_valid (cfg_valid),
  .cfg_fault (cfg_fault),
  .tile_clr  (tile_clr)
);

// File: tb/sim_tcfg_state_unit.sv
module sim_tcfg_state_unit;

  localparam int NT    = 8;
  localparam int B     = 4;
  localparam int BEATS = 64 / B;
  localparam int BW    = $clog2(BEATS);
  localparam int LW    = 8 * B;

  logic          clk;
  logic          rst_n;
  logic          ld_valid;
  logic [LW-1:0] ld_data;
  logic          rel_req;
  logic [BW-1:0] rd_beat;
  logic [LW-1:0] rd_data;
  logic          cfg_valid, cfg_fault, tile_clr;

  int checks = 0;
  int errors = 0;

  logic [7:0] img     [64];
  logic [7:0] exp_cfg [64];
  logic       exp_valid;

  logic [2:0] exp_q [$];
  string      tag_q [$];

  tcfg_state_unit #(.NUM_TILES(NT), .BUS_BYTES(B)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data),
    .rel_req(rel_req), .rd_beat(rd_beat), .rd_data(rd_data),
    .cfg_valid(cfg_valid), .cfg_fault(cfg_fault), .tile_clr(tile_clr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: status triple {fault, valid, clr} after each commit event.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({cfg_fault, cfg_valid, tile_clr} == e, t,
            {29'd0, cfg_fault, cfg_valid, tile_clr}, {29'd0, e});
    end
  end

  function automatic bit img_ok();
    if (img[0] > 8'd1) return 1'b0;
    for (int i = 1; i < 64; i++) begin
      if (i >= 16 && i < 16 + 2 * NT) begin
        if ((i % 2) == 0 && img[i] > 8'd64) return 1'b0;
        if ((i % 2) == 1 && img[i] != 8'd0) return 1'b0;
      end else if (i >= 48 && i < 48 + NT) begin
        if (img[i] > 8'd16) return 1'b0;
      end else if (img[i] != 8'd0) begin
        return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  task automatic make_img(input logic [7:0] pal, input int rbase, input int bbase);
    for (int i = 0; i < 64; i++) img[i] = 8'd0;
    img[0] = pal;
    for (int t = 0; t < NT; t++) begin
      img[16 + 2 * t] = 8'((bbase + 9 * t) % 65);
      img[48 + t]     = 8'((rbase + 5 * t) % 17);
    end
  endtask

  task automatic clear_exp();
    for (int i = 0; i < 64; i++) exp_cfg[i] = 8'd0;
    exp_valid = 1'b0;
  endtask

  // Driver: predicts the outcome, streams the image, queues the expectation.
  task automatic send_image(input string tag, input bit rel_last);
    logic [2:0] e;
    if (rel_last) begin
      e = 3'b001; clear_exp();
    end else if (img[0] == 8'd0) begin
      e = 3'b001; clear_exp();
    end else if (!img_ok()) begin
      e = {1'b1, exp_valid, 1'b0};
    end else begin
      e = 3'b010; exp_valid = 1'b1;
      for (int i = 0; i < 64; i++) exp_cfg[i] = img[i];
    end
    for (int b = 0; b < BEATS; b++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      for (int j = 0; j < B; j++) ld_data[8*j +: 8] = img[b * B + j];
      if (rel_last && b == BEATS - 1) rel_req = 1'b1;
    end
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    ld_valid = 1'b0;
    rel_req  = 1'b0;
  endtask

  task automatic send_partial(input int nbeats);
    for (int b = 0; b < nbeats; b++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      for (int j = 0; j < B; j++) ld_data[8*j +: 8] = img[b * B + j];
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic do_release(input string tag);
    @(negedge clk);
    rel_req = 1'b1;
    @(posedge clk);
    #1;
    clear_exp();
    exp_q.push_back(3'b001);
    tag_q.push_back(tag);
    @(negedge clk);
    rel_req = 1'b0;
  endtask

  task automatic check_readback(input string tag);
    for (int b = 0; b < BEATS; b++) begin
      logic [LW-1:0] want;
      @(negedge clk);
      rd_beat = BW'(b);
      #1;
      for (int j = 0; j < B; j++) want[8*j +: 8] = exp_cfg[b * B + j];
      check(rd_data == want, tag, rd_data, want);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_valid = 1'b0; ld_data = '0; rel_req = 1'b0; rd_beat = '0;
    clear_exp();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check({cfg_fault, cfg_valid, tile_clr} == 3'b000, "R9 reset status",
          {29'd0, cfg_fault, cfg_valid, tile_clr}, 32'd0);
    check_readback("R9 R6 reset readback zero");

    // R1 R2 R3: valid image, lane order visible through readback
    make_img(8'd1, 3, 7);
    send_image("R1 R3 valid load status", 1'b0);
    check_readback("R2 R3 readback of fields");

    // R5 boundary accepted: 16 rows, 64 bytes per row everywhere
    make_img(8'd1, 0, 0);
    for (int t = 0; t < NT; t++) begin img[16 + 2 * t] = 8'd64; img[48 + t] = 8'd16; end
    send_image("R5 limits accepted", 1'b0);
    check_readback("R5 limits readback");

    // R5 rejections, config must stay
    make_img(8'd1, 2, 2); img[48 + 5] = 8'd17;
    send_image("R5 rows 17 rejected", 1'b0);
    make_img(8'd1, 2, 2); img[16 + 2 * 7] = 8'd65;
    send_image("R5 bpr 65 rejected", 1'b0);
    make_img(8'd1, 2, 2); img[17 + 2 * 3] = 8'd1;
    send_image("R5 bpr high byte rejected", 1'b0);
    make_img(8'd1, 2, 2); img[40] = 8'h80;
    send_image("R5 reserved byte rejected", 1'b0);
    make_img(8'd2, 2, 2);
    send_image("R5 palette 2 rejected", 1'b0);
    check_readback("R5 config unchanged after faults");

    // R4: palette zero with junk elsewhere
    make_img(8'd0, 4, 4); img[40] = 8'hff; img[63] = 8'h11;
    send_image("R4 palette zero init", 1'b0);
    check_readback("R4 R6 init readback zero");

    // R7: release after valid load
    make_img(8'd1, 9, 20);
    send_image("R3 reload", 1'b0);
    do_release("R7 release status");
    check_readback("R7 release readback zero");

    // R7: partial image abandoned, next image starts fresh
    make_img(8'd2, 1, 1);
    send_partial(5);
    do_release("R7 release mid image");
    make_img(8'd1, 11, 33);
    send_image("R7 fresh image after abort", 1'b0);
    check_readback("R7 fresh image readback");

    // R8: release on the final beat wins
    make_img(8'd1, 6, 50);
    send_image("R8 release beats final beat", 1'b1);
    check_readback("R8 readback zero");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule